// File: doc/BRIEF.md
# DMA Channel Register Block

This block holds the software-visible state of a single DMA channel. A CPU reaches it over a simple 32-bit memory-mapped bus. There are two kinds of register. The first is a command/status register, which is not a plain storage word: each write is read as a set of commands. Those commands set or clear individual status bits (enable, transfer direction, chain-update armed, completion). The second kind is six plain pointer words that a transfer engine consumes: next, limit, start, stop, next-init and size.

The status bits reach a transfer engine (not part of this block) as registered level outputs. The engine returns a one-cycle completion pulse, which latches a completion flag. While that flag is set, an interrupt request is raised. Software acknowledges the interrupt with a clear command.

Only aligned full-word accesses are decoded. Anything narrower or misaligned is dropped. Reads of unmapped offsets return zero.

Top module: `dmac_chan_regs`

## Requirements
- R1: After synchronous reset, all four status bits, `irq`, all six pointer words and `bus_rdata` are zero.
- R2: A command write to offset 0x0 with bit 0 set sets the enable status bit. With bit 0 clear, that bit is left unchanged.
- R3: A command write with bit 2 set sets the device-to-memory direction bit. Writing bit 2 as zero never clears it.
- R4: A command write with bit 1 set sets the chain-update-armed bit.
- R5: A command write with bit 3 set clears the completion bit.
- R6: A command write with bit 4 set clears enable, direction, chain-update-armed and completion together. This happens even when set bits 0–2 appear in the same write.
- R7: A one-cycle `xfer_done` pulse sets the completion bit. It takes priority over a clear (bit 3) or reset (bit 4) command in the same cycle. `irq` is high exactly while the completion bit is set.
- R8: A read of offset 0x0 returns enable in bit 0, chain-update-armed in bit 1, direction in bit 2 and completion in bit 3. All other bits read zero.
- R9: The pointer words sit at offsets 0x4000 (next), 0x4004 (limit), 0x4008 (start), 0x400C (stop), 0x4200 (next-init) and 0x4204 (size). A full write to one of them is read back unchanged and touches no other word.
- R10: Reads of any other offset return zero. Writes to them change no register.
- R11: An access whose byte enables are not all ones, or whose address bits [1:0] are not zero, is ignored: a write changes nothing and a read returns zero.
- R12: Read data appears on `bus_rdata` in the cycle after the read is presented. In every cycle that follows a non-read, `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset from the channel base |
| bus_be | input | DATA_W/8 | Byte enables; all must be set |
| bus_wdata | input | DATA_W | Write data or command bits |
| bus_rdata | output | DATA_W | Registered read data |
| xfer_done | input | 1 | Completion pulse from the transfer engine |
| chan_enable | output | 1 | Enable status bit |
| chan_dev2mem | output | 1 | Direction status bit (1 = device to memory) |
| chan_upd_armed | output | 1 | Chain-update-armed status bit |
| irq | output | 1 | Completion interrupt request |

## Verification
Some properties are checked by assertions on every cycle:
- a reset command empties the status bits;
- a set command takes effect;
- the direction and enable bits hold still when no command arrives;
- a completion pulse always lands;
- pointer words change only when written;
- read data is zero after a non-read;
- address decode never hits two registers at once.

Other behaviour only the bench's scenarios can show. This covers the priority between a completion pulse and a same-cycle clear or reset, and the sticky nature of the direction bit across many mixed writes. It also covers the readback layout of each register, and the dropping of partial, misaligned and unmapped accesses. The bench shows these by comparing every read and every status output against a model.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  localparam int N_PTR = 6;

  // command bit positions on a control write
  localparam int CMD_SET_EN   = 0;
  localparam int CMD_SET_UPD  = 1;
  localparam int CMD_SET_DIR  = 2;
  localparam int CMD_CLR_DONE = 3;
  localparam int CMD_RESET    = 4;
  localparam int CMD_W        = 5;

  // status word, packed so bit 0 is enable and bit 3 is completion
  typedef struct packed {
    logic done;
    logic dev2mem;
    logic chain_upd;
    logic enable;
  } chan_status_t;

  localparam logic [31:0] CSR_OFFSET = 32'h0000_0000;

  function automatic logic [31:0] ptr_offset(input int idx);
    case (idx)
      0:       return 32'h0000_4000;
      1:       return 32'h0000_4004;
      2:       return 32'h0000_4008;
      3:       return 32'h0000_400C;
      4:       return 32'h0000_4200;
      default: return 32'h0000_4204;
    endcase
  endfunction

endpackage

// File: rtl/dmac_decode.sv
module dmac_decode
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BE_W   = 4,
  parameter int NP     = N_PTR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  output logic              csr_wr,
  output logic              csr_rd,
  output logic [NP-1:0]     ptr_wr,
  output logic [NP-1:0]     ptr_rd
);

  logic          word_ok;
  logic          csr_hit;
  logic [NP-1:0] ptr_hit;

  assign word_ok = sel && (be == '1) && (addr[1:0] == 2'b00);
  assign csr_hit = word_ok && (addr == ADDR_W'(CSR_OFFSET));

  for (genvar i = 0; i < NP; i++) begin : g_hit
    assign ptr_hit[i] = word_ok && (addr == ADDR_W'(ptr_offset(i)));
    assign ptr_wr[i]  = ptr_hit[i] && we;
    assign ptr_rd[i]  = ptr_hit[i] && !we;
  end

  assign csr_wr = csr_hit && we;
  assign csr_rd = csr_hit && !we;

  // R10
  single_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({csr_wr, csr_rd, ptr_wr, ptr_rd}));

endmodule

// File: rtl/dmac_csr.sv
module dmac_csr
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              done_pulse,
  output chan_status_t      status
);

  chan_status_t nxt;
  logic         do_reset;

  assign do_reset = cmd_wr && cmd[CMD_RESET];

  always_comb begin
    nxt = status;
    if (cmd_wr) begin
      if (cmd[CMD_SET_EN])   nxt.enable    = 1'b1;
      if (cmd[CMD_SET_UPD])  nxt.chain_upd = 1'b1;
      if (cmd[CMD_SET_DIR])  nxt.dev2mem   = 1'b1;
      if (cmd[CMD_CLR_DONE]) nxt.done      = 1'b0;
    end
    if (do_reset) begin
      nxt = '0;
    end
    // a completion event is never lost to a same-cycle clear
    if (done_pulse) nxt.done = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= nxt;
  end

  // R6
  reset_cmd_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (do_reset && !done_pulse) |=>
      (status == '0));

  // R2
  set_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd[CMD_SET_EN] && !cmd[CMD_RESET]) |=> status.enable);

  // R3
  bits_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_wr |=> ($stable(status.enable) && $stable(status.dev2mem) &&
                 $stable(status.chain_upd)));

  // R7
  done_lands_chk: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> status.done);

endmodule

// File: rtl/dmac_ptr_bank.sv
module dmac_ptr_bank #(
  parameter int DATA_W = 32,
  parameter int NP     = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NP-1:0]              wr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NP-1:0][DATA_W-1:0]  q
);

  for (genvar i = 0; i < NP; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)        q[i] <= '0;
      else if (wr[i]) q[i] <= wdata;
    end

    // R9
    ptr_store_chk: assert property (@(posedge clk) disable iff (rst)
      wr[i] |=> (q[i] == $past(wdata)));

    // R10
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !wr[i] |=> $stable(q[i]));
  end

endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W/8-1:0]  bus_be,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 xfer_done,
  output logic                 chan_enable,
  output logic                 chan_dev2mem,
  output logic                 chan_upd_armed,
  output logic                 irq
);

  localparam int BE_W = DATA_W / 8;

  logic                      csr_wr, csr_rd;
  logic [N_PTR-1:0]          ptr_wr, ptr_rd;
  logic [N_PTR-1:0][DATA_W-1:0] ptr_q;
  chan_status_t              status;
  logic [DATA_W-1:0]         rd_mux;

  dmac_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W), .NP(N_PTR)) u_decode (
    .clk(clk), .rst(rst), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .be(bus_be), .csr_wr(csr_wr), .csr_rd(csr_rd),
    .ptr_wr(ptr_wr), .ptr_rd(ptr_rd)
  );

  dmac_csr u_csr (
    .clk(clk), .rst(rst), .cmd_wr(csr_wr), .cmd(bus_wdata[CMD_W-1:0]),
    .done_pulse(xfer_done), .status(status)
  );

  dmac_ptr_bank #(.DATA_W(DATA_W), .NP(N_PTR)) u_ptrs (
    .clk(clk), .rst(rst), .wr(ptr_wr), .wdata(bus_wdata), .q(ptr_q)
  );

  always_comb begin
    rd_mux = '0;
    if (csr_rd) rd_mux = DATA_W'(status);
    for (int i = 0; i < N_PTR; i++) begin
      if (ptr_rd[i]) rd_mux = rd_mux | ptr_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  assign chan_enable    = status.enable;
  assign chan_dev2mem   = status.dev2mem;
  assign chan_upd_armed = status.chain_upd;
  assign irq            = status.done;

  // R12
  rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_we) |=> (bus_rdata == '0));

  // R7
  done_irq_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> irq);

  // R3
  dir_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (chan_dev2mem && !(bus_sel && bus_we)) |=> chan_dev2mem);

endmodule

// File: tb/dmac_chan_regs_bench.sv
module dmac_chan_regs_bench;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst;
  logic              bus_sel, bus_we, xfer_done;
  logic [ADDR_W-1:0] bus_addr;
  logic [3:0]        bus_be;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic              chan_enable, chan_dev2mem, chan_upd_armed, irq;

  always #2 clk = ~clk;

  dmac_chan_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dmac_chan_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .xfer_done(xfer_done),
    .chan_enable(chan_enable), .chan_dev2mem(chan_dev2mem),
    .chan_upd_armed(chan_upd_armed), .irq(irq)
  );

  int total = 0;
  int fails = 0;

  logic [3:0]  m_st;      // {done, dir, upd, en}
  logic [31:0] m_ptr [6];

  function automatic logic [15:0] off_of(input int i);
    case (i)
      0: return 16'h4000;  1: return 16'h4004;  2: return 16'h4008;
      3: return 16'h400C;  4: return 16'h4200;  default: return 16'h4204;
    endcase
  endfunction

  function automatic int idx_of(input logic [15:0] a);
    for (int i = 0; i < 6; i++) if (off_of(i) == a) return i;
    return -1;
  endfunction

  function automatic logic [3:0] next_st(input logic [3:0] s,
                                         input logic [31:0] c,
                                         input logic d);
    logic [3:0] n = s;
    if (c[0]) n[0] = 1'b1;
    if (c[1]) n[1] = 1'b1;
    if (c[2]) n[2] = 1'b1;
    if (c[3]) n[3] = 1'b0;
    if (c[4]) n = 4'b0;
    if (d)    n[3] = 1'b1;
    return n;
  endfunction

  function automatic logic [31:0] exp_read(input logic [15:0] a,
                                           input logic [3:0] be);
    int k;
    if (be != 4'hF || a[1:0] != 2'b00) return 32'h0;
    if (a == 16'h0) return {28'h0, m_st};
    k = idx_of(a);
    if (k >= 0) return m_ptr[k];
    return 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outs(input string req);
    check(req, {28'h0, irq, chan_dev2mem, chan_upd_armed, chan_enable},
          {28'h0, m_st});
  endtask

  task automatic idle();
    bus_sel = 0; bus_we = 0; bus_addr = '0; bus_be = '0;
    bus_wdata = '0; xfer_done = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d,
                    input logic [3:0] be, input logic dn, input string req);
    int k;
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    xfer_done = dn;
    @(negedge clk);
    idle();
    if (be == 4'hF && a[1:0] == 2'b00) begin
      if (a == 16'h0) m_st = next_st(m_st, d, dn);
      else begin
        k = idx_of(a);
        if (k >= 0) m_ptr[k] = d;
        if (dn) m_st[3] = 1'b1;
      end
    end else if (dn) m_st[3] = 1'b1;
    check_outs(req);
  endtask

  task automatic rd(input logic [15:0] a, input logic [3:0] be,
                    input string req);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a; bus_be = be;
    @(negedge clk);
    idle();
    check(req, bus_rdata, exp_read(a, be));
  endtask

  task automatic pulse_done(input string req);
    @(negedge clk);
    xfer_done = 1;
    @(negedge clk);
    idle();
    m_st[3] = 1'b1;
    check_outs(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] a;
    logic [31:0] d;
    void'($urandom(32'h1d5e_ed01));
    idle();
    rst = 1;
    m_st = '0;
    for (int i = 0; i < 6; i++) m_ptr[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    check_outs("R1 status");
    check("R1 rdata", bus_rdata, 32'h0);
    for (int i = 0; i < 6; i++) rd(off_of(i), 4'hF, "R1 ptr");

    // R2 set enable, zero leaves
    wr(16'h0, 32'h01, 4'hF, 0, "R2 set enable");
    wr(16'h0, 32'h00, 4'hF, 0, "R2 zero leaves enable");
    // R3 direction sticky
    wr(16'h0, 32'h04, 4'hF, 0, "R3 set dir");
    wr(16'h0, 32'h02, 4'hF, 0, "R4 set chain update, R3 dir kept");
    // R8 layout
    rd(16'h0, 4'hF, "R8 csr layout");
    // R7 done and irq
    pulse_done("R7 done sets irq");
    rd(16'h0, 4'hF, "R8 csr with done");
    // R5 clear complete
    wr(16'h0, 32'h08, 4'hF, 0, "R5 clear complete");
    // R7 priority over clear
    wr(16'h0, 32'h08, 4'hF, 1, "R7 done beats clear");
    // R6 reset wins over sets
    wr(16'h0, 32'h17, 4'hF, 0, "R6 reset wins");
    rd(16'h0, 4'hF, "R6 csr empty");
    // R7 priority over reset
    wr(16'h0, 32'h10, 4'hF, 1, "R7 done beats reset");
    wr(16'h0, 32'h18, 4'hF, 0, "R6 reset clears done");

    // R9 pointer words
    for (int i = 0; i < 6; i++)
      wr(off_of(i), 32'hA5A5_0000 | i, 4'hF, 0, "R9 ptr write");
    for (int i = 0; i < 6; i++) rd(off_of(i), 4'hF, "R9 ptr readback");

    // R10 unmapped
    wr(16'h4010, 32'hFFFF_FFFF, 4'hF, 0, "R10 unmapped write");
    rd(16'h4010, 4'hF, "R10 unmapped read");
    rd(16'h0004, 4'hF, "R10 unmapped read low");
    for (int i = 0; i < 6; i++) rd(off_of(i), 4'hF, "R10 ptrs untouched");

    // R11 partial and misaligned
    wr(16'h4004, 32'h1234_5678, 4'h3, 0, "R11 partial write");
    rd(16'h4004, 4'hF, "R11 partial write ignored");
    wr(16'h4006, 32'h1234_5678, 4'hF, 0, "R11 misaligned write");
    rd(16'h4004, 4'hF, "R11 misaligned write ignored");
    wr(16'h0, 32'h05, 4'h1, 0, "R11 partial csr write ignored");
    rd(16'h4004, 4'h7, "R11 partial read zero");
    rd(16'h4005, 4'hF, "R11 misaligned read zero");

    // R12 rdata zero after non-read
    rd(16'h4000, 4'hF, "R12 read");
    @(negedge clk);
    check("R12 rdata idle zero", bus_rdata, 32'h0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom_range(0, 5));
      d = $urandom;
      case (op)
        0: wr(16'h0, d & 32'h1F, 4'hF, $urandom_range(0, 3) == 0,
              "R6 random command");
        1: wr(off_of(int'($urandom_range(0, 5))), d, 4'hF, 0,
              "R9 random ptr write");
        2: rd(off_of(int'($urandom_range(0, 5))), 4'hF,
              "R9 random ptr read");
        3: rd(16'h0, 4'hF, "R8 random csr read");
        4: begin
          a = 16'($urandom) & 16'hFFFC;
          if ($urandom_range(0, 1) == 1) wr(a, d, 4'hF, 0, "R10 random write");
          else rd(a, 4'hF, "R10 random read");
        end
        default: begin
          a = 16'($urandom);
          wr(a, d, 4'($urandom), 0, "R11 random odd access");
          rd(a, 4'($urandom), "R11 random odd read");
        end
      endcase
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule